// File: doc/BRIEF.md
# Packet buffer pointer data port

This block gives byte-wide access to a packet memory split into 2048-byte frames. Software positions a 16-bit pointer register, whose low 11 bits are a byte offset inside a frame and whose upper five bits are control and flag bits. It then moves data through a four-byte data window. Each window access picks a frame from a packet number. The byte address is resolved in one of two ways. In the first, the pointer is used as is and then stepped forward. In the second, the window lane is added to the pointer, which stays where it is.

Data moves on a request channel and a read-response channel, both valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A read answers one cycle after it is accepted. A pending response stays valid, with its data held, until `rsp_ready` is seen high. While a response waits and `rsp_ready` is low, `req_ready` is low and further requests stall. The pointer register is loaded through plain byte strobes.

Top module: `pkt_ptr_port`

## Requirements
- R1: After reset the pointer register reads 0x0000, `rsp_valid` is low and `req_ready` is high.
- R2: A low-byte strobe replaces pointer bits 7:0 and a high-byte strobe replaces bits 15:8. The other byte keeps its value.
- R3: When pointer bit 14 (autoincrement) is set, an accepted access to a valid packet uses pointer bits 10:0 as its byte address. Bits 10:0 then step by one modulo 2048, so 2047 goes to 0. The new value is visible on `ptr_q` the cycle after acceptance.
- R4: Stepping the pointer never changes pointer bits 15:11.
- R5: When bit 14 is clear, the access address is (pointer bits 10:0 + `req_lane`) modulo 2048 and the pointer does not change. Lane 3 at pointer 2047 addresses byte 2.
- R6: An access whose `req_pkt` is NUM_FRAMES or above is ignored. A write changes no memory byte. A read returns 0x00. The pointer does not change.
- R7: For a valid packet the frame is `req_pkt` modulo NUM_FRAMES. Frames do not alias each other.
- R8: A read accepted on one edge drives `rsp_valid` high after that edge, with the addressed byte on `rsp_data`.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` stays stable and `req_ready` is low. No request is accepted and the pointer does not step.
- R10: When a pointer strobe and an autoincrement access happen in the same cycle, the access still uses the old pointer. The pointer takes the written byte and no increment is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr_lo | input | 1 | Load pointer bits 7:0 from `ptr_wdata` |
| ptr_wr_hi | input | 1 | Load pointer bits 15:8 from `ptr_wdata` |
| ptr_wdata | input | 8 | Byte written into the pointer register |
| ptr_q | output | 16 | Current pointer register |
| req_valid | input | 1 | Window access request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lane | input | 2 | Byte lane of the data window |
| req_pkt | input | PKT_W | Packet number selecting the frame |
| req_wdata | input | 8 | Write data byte |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 8 | Read data byte |

## Verification
The hardest case to reach from the ports is a stalled response that collides with a held request while autoincrement is on. The check is that the pointer steps exactly once for each accepted read. The bench gets there by issuing an autoincrement read with `rsp_ready` low and keeping `req_valid` high through the stall. It then releases `rsp_ready` and checks the data and pointer at each cycle. The wrap from 2047 to 0 is reached by sweeping whole frames through autoincrement with flag bits set. The lane wrap is reached by placing the pointer at the last bytes of a frame and walking all four lanes.

// File: rtl/pkt_ptr_pkg.sv
package pkt_ptr_pkg;
  localparam int PTR_W       = 11;
  localparam int FRAME_BYTES = 1 << PTR_W;
  localparam int LANES       = 4;
  localparam int LANE_W      = $clog2(LANES);

  typedef struct packed {
    logic             rx_area;
    logic             auto_inc;
    logic             rd_flag;
    logic             spare;
    logic             busy_flag;
    logic [PTR_W-1:0] offset;
  } ptr_reg_t;
endpackage

// File: rtl/pkt_ptr_reg.sv
module pkt_ptr_reg
  import pkt_ptr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_lo,
  input  logic     wr_hi,
  input  logic [7:0] wdata,
  input  logic     step,
  output ptr_reg_t ptr
);
  logic [15:0] cur, nxt;
  assign cur = ptr;

  always_comb begin
    nxt = cur;
    if (wr_lo || wr_hi) begin
      if (wr_lo) nxt[7:0]  = wdata;
      if (wr_hi) nxt[15:8] = wdata;
    end else if (step) begin
      nxt[PTR_W-1:0] = cur[PTR_W-1:0] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= nxt;
  end

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_lo && !wr_hi) |=> ptr.offset == $past(ptr.offset) + 11'd1); // R3
  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi) |=> ptr[15:PTR_W] == $past(ptr[15:PTR_W])); // R4
  AST_STRAY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_lo && !wr_hi) |=> $stable(ptr)); // R5
endmodule

// File: rtl/pkt_addr_resolve.sv
module pkt_addr_resolve
  import pkt_ptr_pkg::*;
(
  input  ptr_reg_t          ptr,
  input  logic [LANE_W-1:0] lane,
  output logic [PTR_W-1:0]  byte_addr
);
  always_comb begin
    if (ptr.auto_inc) byte_addr = ptr.offset;
    else              byte_addr = ptr.offset + PTR_W'(lane);
  end
endmodule

// File: rtl/pkt_frame_mem.sv
module pkt_frame_mem
  import pkt_ptr_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  localparam int SEL_W  = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int ADDR_W = SEL_W + PTR_W
)(
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int WORDS  = NUM_FRAMES * FRAME_BYTES / LANES;
  localparam int WIDX_W = ADDR_W - LANE_W;

  logic [8*LANES-1:0] mem [WORDS];
  logic [8*LANES-1:0] word_q;
  logic [LANE_W-1:0]  sel_q;
  logic [WIDX_W-1:0]  widx;
  logic [LANE_W-1:0]  bsel;

  assign widx = addr[ADDR_W-1:LANE_W];
  assign bsel = addr[LANE_W-1:0];

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && bsel == LANE_W'(b)) mem[widx][8*b +: 8] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      word_q <= mem[widx];
      sel_q  <= bsel;
    end
  end

  assign rdata = word_q[8*sel_q +: 8];
endmodule

// File: rtl/pkt_ptr_port.sv
module pkt_ptr_port
  import pkt_ptr_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int PKT_W      = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_wr_lo,
  input  logic             ptr_wr_hi,
  input  logic [7:0]       ptr_wdata,
  output logic [15:0]      ptr_q,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_lane,
  input  logic [PKT_W-1:0] req_pkt,
  input  logic [7:0]       req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data
);
  localparam int SEL_W  = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
  localparam int ADDR_W = SEL_W + PTR_W;

  ptr_reg_t         ptr;
  logic [PTR_W-1:0] byte_addr;
  logic             acc, pkt_ok, step, rd_acc;
  logic             zero_q;
  logic [7:0]       mem_rd;
  logic [SEL_W-1:0] frame;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign pkt_ok    = req_pkt < PKT_W'(NUM_FRAMES);
  assign step      = acc && pkt_ok && ptr.auto_inc;
  assign rd_acc    = acc && !req_write;
  assign frame     = req_pkt[SEL_W-1:0];

  pkt_ptr_reg u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_lo(ptr_wr_lo), .wr_hi(ptr_wr_hi),
    .wdata(ptr_wdata), .step(step), .ptr(ptr)
  );

  pkt_addr_resolve u_res (.ptr(ptr), .lane(req_lane), .byte_addr(byte_addr));

  pkt_frame_mem #(.NUM_FRAMES(NUM_FRAMES)) u_mem (
    .clk(clk), .we(acc && req_write && pkt_ok), .re(rd_acc && pkt_ok),
    .addr({frame, byte_addr}), .wdata(req_wdata), .rdata(mem_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      zero_q    <= 1'b1;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      zero_q    <= !pkt_ok;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_data = zero_q ? 8'h00 : mem_rd;
  assign ptr_q    = ptr;

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid); // R8
  AST_BAD_PKT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !pkt_ok) |=> rsp_data == 8'h00); // R6
  AST_BAD_PKT_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pkt_ok && !ptr_wr_lo && !ptr_wr_hi) |=> $stable(ptr_q)); // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data)); // R9
endmodule

// File: tb/pkt_ptr_port_test.sv
module pkt_ptr_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;

  logic clk = 0, rst_n = 0;
  logic ptr_wr_lo = 0, ptr_wr_hi = 0;
  logic [7:0] ptr_wdata = 0;
  logic [15:0] ptr_q;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [1:0] req_lane = 0;
  logic [5:0] req_pkt = 0;
  logic [7:0] req_wdata = 0;
  logic rsp_valid, rsp_ready = 1;
  logic [7:0] rsp_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [NF*2048];

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_ptr_port uut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int f, int a);
    return 8'((a * 13 + f * 67 + (a >> 7)) & 255);
  endfunction

  task automatic set_ptr(logic [15:0] v);
    ptr_wr_lo = 1; ptr_wdata = v[7:0];
    @(negedge clk); ptr_wr_lo = 0;
    ptr_wr_hi = 1; ptr_wdata = v[15:8];
    @(negedge clk); ptr_wr_hi = 0;
  endtask

  task automatic access(bit wr, int pkt, int lane, logic [7:0] wd, output logic [7:0] rd);
    req_valid = 1; req_write = wr; req_pkt = 6'(pkt); req_lane = 2'(lane); req_wdata = wd;
    @(negedge clk);
    rd = rsp_data;
    req_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [15:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 ptr", ptr_q, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 req_ready", req_ready, 1);

    // R2 byte strobes
    ptr_wr_lo = 1; ptr_wdata = 8'h34; @(negedge clk); ptr_wr_lo = 0;
    check("R2 lo", ptr_q, 16'h0034);
    ptr_wr_hi = 1; ptr_wdata = 8'h52; @(negedge clk); ptr_wr_hi = 0;
    check("R2 hi", ptr_q, 16'h5234);
    ptr_wr_lo = 1; ptr_wdata = 8'hAB; @(negedge clk); ptr_wr_lo = 0;
    check("R2 lo keep hi", ptr_q, 16'h52AB);

    // R3 R4 R7: fill every frame via autoincrement with flag bits set
    for (int f = 0; f < NF; f++) begin
      set_ptr(16'hE800);
      for (int a = 0; a < 2048; a++) begin
        access(1, f, a & 3, pat(f, a), rd);
        model[f*2048 + a] = pat(f, a);
        if (a == 1000) check("R3 step", ptr_q, 16'hE800 | 1001);
      end
      check("R3 R4 wrap keeps flags", ptr_q, 16'hE800);
    end

    // R3 R8 R7: exhaustive readback
    for (int f = 0; f < NF; f++) begin
      set_ptr(16'h4000 | 16'(f * 300));
      for (int i = 0; i < 2048; i++) begin
        int a;
        a = (f * 300 + i) % 2048;
        access(0, f, 3, 8'h00, rd);
        check("R8 rsp_valid", rsp_valid, 1);
        check("R3 R7 data", rd, model[f*2048 + a]);
        check("R3 ptr", ptr_q, 16'h4000 | 16'((a + 1) % 2048));
      end
    end

    // R5 lane addressing without autoincrement, including wrap
    for (int k = 0; k < 8; k++) begin
      int base;
      base = (k < 4) ? (2044 + k) : (k * 5);
      p = 16'(base) | 16'hA800;
      set_ptr(p);
      for (int l = 0; l < 4; l++) begin
        access(0, k % NF, l, 8'h00, rd);
        check("R5 data", rd, model[(k % NF)*2048 + ((base + l) % 2048)]);
        check("R5 ptr hold", ptr_q, p);
      end
    end
    set_ptr(16'h0010);
    access(1, 1, 3, 8'h5A, rd);
    model[2048 + 16'h13] = 8'h5A;
    set_ptr(16'h0013);
    access(0, 1, 0, 8'h00, rd);
    check("R5 lane write", rd, 8'h5A);

    // R6 invalid packet numbers
    set_ptr(16'h4020);
    access(1, 4, 0, 8'hFF, rd);
    check("R6 write ptr", ptr_q, 16'h4020);
    access(1, 63, 0, 8'hFF, rd);
    access(0, 5, 0, 8'h00, rd);
    check("R6 read zero", rd, 0);
    check("R6 read valid", rsp_valid, 1);
    check("R6 read ptr", ptr_q, 16'h4020);
    access(0, 0, 0, 8'h00, rd);
    check("R6 mem untouched", rd, model[16'h20]);

    // R10 pointer write beats increment
    set_ptr(16'h4005);
    ptr_wr_lo = 1; ptr_wdata = 8'h20;
    access(0, 2, 0, 8'h00, rd);
    ptr_wr_lo = 0;
    check("R10 old addr", rd, model[2*2048 + 5]);
    check("R10 ptr", ptr_q, 16'h4020);

    // R9 back-pressure
    set_ptr(16'h4100);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_pkt = 3;
    @(negedge clk);
    check("R9 data0", rsp_data, model[3*2048 + 16'h100]);
    check("R9 ready low", req_ready, 0);
    check("R9 ptr once", ptr_q, 16'h4101);
    @(negedge clk);
    check("R9 data stable", rsp_data, model[3*2048 + 16'h100]);
    check("R9 ptr stall", ptr_q, 16'h4101);
    check("R9 valid held", rsp_valid, 1);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R9 data1", rsp_data, model[3*2048 + 16'h101]);
    check("R9 ptr after", ptr_q, 16'h4102);
    @(negedge clk);
    check("R9 drained", rsp_valid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule